// File: doc/BRIEF.md
# Clock Output Stop Gating Controller

This block sits between one reference clock and eight differential clock output channels. It derives a half-rate output clock from the reference, and for each channel it decides every output period whether the true/complement pair runs, parks with the true line held high, or has both lines released to high impedance. It does not drive pads. It produces the logic level and a separate drive-enable flag for each line of every pair, and pad cells downstream act on those flags.

Three asynchronous active-low requests feed it: a stop request, a power-down request and one enable pin per channel. Each passes through a two-flop synchroniser and then a settle filter that samples once per output period, on the rising edge of the complement clock. A level is accepted only when two such samples in a row agree. A configuration shadow holds the per-channel stop mask, the per-channel enables and the two drive-mode bits. It loads them on a one-cycle strobe and returns to its defaults on reset. A channel changes state only on the edge that starts the low half of its clock, so no output shows a shortened pulse.

Top module: `clkout_stop_gate`

## Requirements
- R1: A change on the stop, power-down or enable pins takes effect only after two consecutive complement-rising samples, one output period apart, see the same level. A pulse shorter than one output period never changes any output.
- R2: A recognised stop (stop_req_n low) halts only the channels whose stop-mask bit is 1. The other channels keep toggling. After reset every mask bit is 0, so a stop halts no channel until a mask is loaded.
- R3: With cfg_stop_float = 0, a stopped channel drives its true line high (t_oe=1, t_out=1) and releases its complement line (c_oe=0, c_out=0). With cfg_stop_float = 1, both lines are released (t_oe=0, c_oe=0, both outputs 0).
- R4: When the stop is withdrawn, all stopped channels resume in the same cycle. They do so between 2 and 6 output periods (4 to 12 reference cycles) after the pin changes.
- R5: A channel is released on both lines whenever its enable pin is low, or its cfg_chan_en bit is 0, or both. This takes priority over stop and power-down.
- R6: A recognised power-down (pwrdn_n low) parks every enabled channel, whatever its stop-mask bit. With cfg_pd_float = 0 the true line is driven high and the complement line is released. With cfg_pd_float = 1 both lines are released. Power-down takes priority over stop.
- R7: During reset all outputs and drive flags are 0. After reset the channels run, all register enables are 1 and both drive modes are 0 (driven).
- R8: A running channel drives both lines (t_oe=c_oe=1). The complement line is always the inverse of the true line, and the true line toggles every reference cycle.
- R9: State changes are applied at the start of a low half-period. When a channel's true-line driver turns on, its first driven value is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req_n | input | 1 | Asynchronous stop request, active low |
| pwrdn_n | input | 1 | Asynchronous power-down request, active low |
| chan_en_pin | input | NUM_CH | Asynchronous per-channel enable pins; 0 releases the channel |
| cfg_load | input | 1 | One-cycle strobe that captures the four cfg_* fields |
| cfg_stop_mask | input | NUM_CH | Per-channel stop mask; 1 = channel halts on stop |
| cfg_chan_en | input | NUM_CH | Per-channel register enable; 0 = released |
| cfg_stop_float | input | 1 | Stop drive mode; 1 = release both lines |
| cfg_pd_float | input | 1 | Power-down drive mode; 1 = release both lines |
| t_out | output | NUM_CH | True line level per channel |
| c_out | output | NUM_CH | Complement line level per channel |
| t_oe | output | NUM_CH | True line drive enable per channel |
| c_oe | output | NUM_CH | Complement line drive enable per channel |

## Verification
The properties assume the reference clock runs without interruption. They also assume rst_n is the only thing that starts the phase counter, so a complement-rising sample falls on every other reference edge. The asynchronous pins may change at any time. The bench still drives them only between edges, so the model can name the edge that first sees each new level. The configuration fields are assumed stable except in the cycle that cfg_load is high, and the bench changes them only through that strobe.

// File: rtl/clkout_stop_gate_pkg.sv
package clkout_stop_gate_pkg;

  typedef enum logic [1:0] {
    CH_RUN   = 2'd0,
    CH_PARK  = 2'd1,
    CH_FLOAT = 2'd2
  } ch_state_e;

  typedef struct packed {
    logic t;
    logic c;
    logic t_oe;
    logic c_oe;
  } pair_drv_t;

  // Accept a new sample only where it matches the previous one.
  function automatic logic [63:0] settle_levels(input logic [63:0] fresh,
                                                input logic [63:0] last,
                                                input logic [63:0] held);
    logic [63:0] differ;
    differ = fresh ^ last;
    return (fresh & ~differ) | (held & differ);
  endfunction

  // Priority: disable, then power-down, then masked stop.
  function automatic ch_state_e pick_state(input logic enabled,
                                           input logic pd_req,
                                           input logic pd_float,
                                           input logic stop_req,
                                           input logic stoppable,
                                           input logic stop_float);
    if (!enabled)                  return CH_FLOAT;
    else if (pd_req)               return pd_float ? CH_FLOAT : CH_PARK;
    else if (stop_req && stoppable) return stop_float ? CH_FLOAT : CH_PARK;
    else                           return CH_RUN;
  endfunction

  function automatic pair_drv_t pair_drive(input ch_state_e st, input logic phase);
    pair_drv_t d;
    case (st)
      CH_RUN:  d = '{t: phase, c: ~phase, t_oe: 1'b1, c_oe: 1'b1};
      CH_PARK: d = '{t: 1'b1,  c: 1'b0,   t_oe: 1'b1, c_oe: 1'b0};
      default: d = '{t: 1'b0,  c: 1'b0,   t_oe: 1'b0, c_oe: 1'b0};
    endcase
    return d;
  endfunction

endpackage

// File: rtl/csg_level_filter.sv
module csg_level_filter #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sample,
  input  logic [W-1:0] din,
  output logic [W-1:0] level_next,
  output logic [W-1:0] level_q
);
  import clkout_stop_gate_pkg::*;

  logic [W-1:0] meta_q, sync_q, prev_q;
  logic [63:0]  merged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= RST_VAL;
      sync_q  <= RST_VAL;
      prev_q  <= RST_VAL;
      level_q <= RST_VAL;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      if (sample) begin
        prev_q  <= sync_q;
        level_q <= level_next;
      end
    end
  end

  always_comb begin
    merged     = settle_levels(64'(sync_q), 64'(prev_q), 64'(level_q));
    level_next = merged[W-1:0];
  end

endmodule

// File: rtl/csg_cfg_shadow.sv
module csg_cfg_shadow #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [NUM_CH-1:0] mask_in,
  input  logic [NUM_CH-1:0] en_in,
  input  logic              stop_float_in,
  input  logic              pd_float_in,
  output logic [NUM_CH-1:0] mask_q,
  output logic [NUM_CH-1:0] en_q,
  output logic              stop_float_q,
  output logic              pd_float_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q       <= '0;
      en_q         <= '1;
      stop_float_q <= 1'b0;
      pd_float_q   <= 1'b0;
    end else if (load) begin
      mask_q       <= mask_in;
      en_q         <= en_in;
      stop_float_q <= stop_float_in;
      pd_float_q   <= pd_float_in;
    end
  end

endmodule

// File: rtl/csg_channel.sv
module csg_channel (
  input  logic clk,
  input  logic rst_n,
  input  logic update,
  input  logic phase_next,
  input  logic enabled,
  input  logic pd_req,
  input  logic pd_float,
  input  logic stop_req,
  input  logic stoppable,
  input  logic stop_float,
  output logic t_out,
  output logic c_out,
  output logic t_oe,
  output logic c_oe
);
  import clkout_stop_gate_pkg::*;

  ch_state_e st_q;
  pair_drv_t drv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CH_RUN;
      drv_q <= '0;
    end else begin
      if (update)
        st_q <= pick_state(enabled, pd_req, pd_float, stop_req, stoppable, stop_float);
      drv_q <= pair_drive(st_q, phase_next);
    end
  end

  assign t_out = drv_q.t;
  assign c_out = drv_q.c;
  assign t_oe  = drv_q.t_oe;
  assign c_oe  = drv_q.c_oe;

endmodule

// File: rtl/clkout_stop_gate.sv
module clkout_stop_gate #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_req_n,
  input  logic              pwrdn_n,
  input  logic [NUM_CH-1:0] chan_en_pin,
  input  logic              cfg_load,
  input  logic [NUM_CH-1:0] cfg_stop_mask,
  input  logic [NUM_CH-1:0] cfg_chan_en,
  input  logic              cfg_stop_float,
  input  logic              cfg_pd_float,
  output logic [NUM_CH-1:0] t_out,
  output logic [NUM_CH-1:0] c_out,
  output logic [NUM_CH-1:0] t_oe,
  output logic [NUM_CH-1:0] c_oe
);

  localparam int CTL_W = 2;
  localparam int STOP_BIT = 0;
  localparam int PD_BIT = 1;

  // Half-rate output phase; high means the true clock is high.
  logic phase_q;
  logic phase_next;
  logic cmp_rise_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= phase_next;
  end

  assign phase_next  = ~phase_q;
  assign cmp_rise_ev = phase_q;   // this edge drops true, raises complement

  logic [CTL_W-1:0]  ctl_next, ctl_q;
  logic [NUM_CH-1:0] en_pin_next, en_pin_q;

  csg_level_filter #(.W(CTL_W), .RST_VAL({CTL_W{1'b1}})) u_ctl_filt (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample     (cmp_rise_ev),
    .din        ({pwrdn_n, stop_req_n}),
    .level_next (ctl_next),
    .level_q    (ctl_q)
  );

  csg_level_filter #(.W(NUM_CH), .RST_VAL({NUM_CH{1'b1}})) u_en_filt (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample     (cmp_rise_ev),
    .din        (chan_en_pin),
    .level_next (en_pin_next),
    .level_q    (en_pin_q)
  );

  // Named events for the checker.
  logic              stop_seen, pd_seen;
  logic [NUM_CH-1:0] en_seen;
  assign stop_seen = ~ctl_q[STOP_BIT];
  assign pd_seen   = ~ctl_q[PD_BIT];
  assign en_seen   = en_pin_q;

  logic [NUM_CH-1:0] mask_q, reg_en_q;
  logic              stop_float_q, pd_float_q;

  csg_cfg_shadow #(.NUM_CH(NUM_CH)) u_cfg (
    .clk           (clk),
    .rst_n         (rst_n),
    .load          (cfg_load),
    .mask_in       (cfg_stop_mask),
    .en_in         (cfg_chan_en),
    .stop_float_in (cfg_stop_float),
    .pd_float_in   (cfg_pd_float),
    .mask_q        (mask_q),
    .en_q          (reg_en_q),
    .stop_float_q  (stop_float_q),
    .pd_float_q    (pd_float_q)
  );

  logic              stop_now, pd_now;
  logic [NUM_CH-1:0] chan_enabled;
  assign stop_now     = ~ctl_next[STOP_BIT];
  assign pd_now       = ~ctl_next[PD_BIT];
  assign chan_enabled = en_pin_next & reg_en_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    csg_channel u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .update     (cmp_rise_ev),
      .phase_next (phase_next),
      .enabled    (chan_enabled[g]),
      .pd_req     (pd_now),
      .pd_float   (pd_float_q),
      .stop_req   (stop_now),
      .stoppable  (mask_q[g]),
      .stop_float (stop_float_q),
      .t_out      (t_out[g]),
      .c_out      (c_out[g]),
      .t_oe       (t_oe[g]),
      .c_oe       (c_oe[g])
    );
  end

endmodule

// File: rtl/clkout_stop_gate_chk.sv
module clkout_stop_gate_chk #(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmp_rise_ev,
  input logic              stop_seen,
  input logic              pd_seen,
  input logic [NUM_CH-1:0] en_seen,
  input logic [NUM_CH-1:0] t_out,
  input logic [NUM_CH-1:0] c_out,
  input logic [NUM_CH-1:0] t_oe,
  input logic [NUM_CH-1:0] c_oe
);

  AST_STOP_ON_SAMPLE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stop_seen) |-> $past(cmp_rise_ev)); // R1

  AST_PD_RELEASES_COMP: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_seen && $past(pd_seen) && $past(pd_seen, 2)) |-> (c_oe == '0)); // R6

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ast
    AST_PAIR_OPPOSED: assert property (@(posedge clk) disable iff (!rst_n)
      (t_oe[g] && c_oe[g]) |-> (t_out[g] != c_out[g])); // R8

    AST_RUN_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
      (t_oe[g] && c_oe[g] && $past(t_oe[g]) && $past(c_oe[g])) |-> (t_out[g] != $past(t_out[g]))); // R8

    AST_DRIVER_WAKES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(t_oe[g]) |-> t_out[g]); // R9

    AST_COMP_NEEDS_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
      c_oe[g] |-> t_oe[g]); // R3

    AST_PIN_LOW_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_seen[g] && !$past(en_seen[g])) |-> (!t_oe[g] && !c_oe[g])); // R5
  end

endmodule

bind clkout_stop_gate clkout_stop_gate_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmp_rise_ev (cmp_rise_ev),
  .stop_seen   (stop_seen),
  .pd_seen     (pd_seen),
  .en_seen     (en_seen),
  .t_out       (t_out),
  .c_out       (c_out),
  .t_oe        (t_oe),
  .c_oe        (c_oe)
);

// File: tb/sim_clkout_stop_gate.sv
module sim_clkout_stop_gate;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req_n = 1'b1, pwrdn_n = 1'b1, cfg_load = 1'b0;
  logic cfg_stop_float = 1'b0, cfg_pd_float = 1'b0;
  logic [N-1:0] chan_en_pin = '1, cfg_stop_mask = '0, cfg_chan_en = '1;
  logic [N-1:0] t_out, c_out, t_oe, c_oe;

  always #4 clk = ~clk;

  clkout_stop_gate #(.NUM_CH(N)) u0 (
    .clk(clk), .rst_n(rst_n), .stop_req_n(stop_req_n), .pwrdn_n(pwrdn_n),
    .chan_en_pin(chan_en_pin), .cfg_load(cfg_load), .cfg_stop_mask(cfg_stop_mask),
    .cfg_chan_en(cfg_chan_en), .cfg_stop_float(cfg_stop_float), .cfg_pd_float(cfg_pd_float),
    .t_out(t_out), .c_out(c_out), .t_oe(t_oe), .c_oe(c_oe));

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit            m_ph;
  logic [N+1:0]  m_pipe[$];          // {enable pins, pwrdn_n, stop_req_n}
  logic [N+1:0]  m_prev, m_lvl;
  int            m_mode[N];          // 0 run, 1 park high, 2 released
  logic [N-1:0]  m_mask, m_en;
  bit            m_sf, m_pf;
  logic [N-1:0]  e_t, e_c, e_to, e_co;

  task automatic model_reset();
    m_ph = 1'b0;
    m_pipe.delete();
    m_pipe.push_back('1);
    m_pipe.push_back('1);
    m_prev = '1; m_lvl = '1;
    for (int i = 0; i < N; i++) m_mode[i] = 0;
    m_mask = '0; m_en = '1; m_sf = 1'b0; m_pf = 1'b0;
    e_t = '0; e_c = '0; e_to = '0; e_co = '0;
  endtask

  task automatic model_step();
    logic [N+1:0] seen, agreed;
    bit ev;
    ev = m_ph;
    seen = m_pipe.pop_front();
    m_pipe.push_back({chan_en_pin, pwrdn_n, stop_req_n});
    for (int i = 0; i < N; i++) begin
      if (m_mode[i] == 0)      begin e_t[i] = ~m_ph; e_c[i] = m_ph; e_to[i] = 1'b1; e_co[i] = 1'b1; end
      else if (m_mode[i] == 1) begin e_t[i] = 1'b1;  e_c[i] = 1'b0; e_to[i] = 1'b1; e_co[i] = 1'b0; end
      else                     begin e_t[i] = 1'b0;  e_c[i] = 1'b0; e_to[i] = 1'b0; e_co[i] = 1'b0; end
    end
    if (ev) begin
      for (int b = 0; b < N + 2; b++) agreed[b] = (seen[b] == m_prev[b]) ? seen[b] : m_lvl[b];
      m_prev = seen;
      m_lvl  = agreed;
      for (int i = 0; i < N; i++) begin
        if (!(agreed[2+i] && m_en[i]))        m_mode[i] = 2;
        else if (!agreed[1])                  m_mode[i] = m_pf ? 2 : 1;
        else if (!agreed[0] && m_mask[i])     m_mode[i] = m_sf ? 2 : 1;
        else                                  m_mode[i] = 0;
      end
    end
    if (cfg_load) begin
      m_mask = cfg_stop_mask; m_en = cfg_chan_en; m_sf = cfg_stop_float; m_pf = cfg_pd_float;
    end
    m_ph = ~m_ph;
  endtask

  always @(negedge clk) begin
    if (!rst_n) model_reset();
    else if (!done) begin
      string tag;
      model_step();
      tag = "R8";
      for (int i = N - 1; i >= 0; i--)
        if ({t_out[i], c_out[i], t_oe[i], c_oe[i]} != {e_t[i], e_c[i], e_to[i], e_co[i]})
          tag = (e_to[i] && e_co[i]) ? "R8" : (e_to[i] ? "R3" : "R5");
      check({t_out, c_out, t_oe, c_oe} == {e_t, e_c, e_to, e_co}, {tag, " model"},
            {t_out, c_out, t_oe, c_oe}, {e_t, e_c, e_to, e_co});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_cfg(input logic [N-1:0] mask, input logic [N-1:0] en, input bit sf, input bit pf);
    @(negedge clk); #1;
    cfg_stop_mask = mask; cfg_chan_en = en; cfg_stop_float = sf; cfg_pd_float = pf;
    cfg_load = 1'b1;
    @(negedge clk); #1;
    cfg_load = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    bit quiet, differ, together;
    int lat;
    logic prev_t7;
    cyc(3);
    check({t_out, c_out, t_oe, c_oe} == '0, "R7 outputs in reset", {t_out, c_out, t_oe, c_oe}, 0);
    @(negedge clk); #1 rst_n = 1'b1;
    cyc(4);
    check(t_oe == '1 && c_oe == '1, "R7 running after reset", {t_oe, c_oe}, 16'hFFFF);

    // R2: default mask 0 -> a stop halts nothing
    @(negedge clk); #1 stop_req_n = 1'b0;
    cyc(20);
    check(c_oe == '1, "R2 reset mask stops nothing", c_oe, 8'hFF);
    @(negedge clk); #1 stop_req_n = 1'b1;
    cyc(12);

    // R1: a one-cycle stop pulse is never recognised
    load_cfg(8'h0F, '1, 1'b0, 1'b0);
    cyc(4);
    @(negedge clk); #1 stop_req_n = 1'b0;
    @(negedge clk); #1 stop_req_n = 1'b1;
    quiet = 1'b1;
    for (int k = 0; k < 16; k++) begin @(negedge clk); if (c_oe != '1) quiet = 1'b0; end
    check(quiet, "R1 short pulse ignored", c_oe, 8'hFF);

    // R2 / R3: masked channels park high, others run
    @(negedge clk); #1 stop_req_n = 1'b0;
    cyc(16);
    check(c_oe == 8'hF0 && t_oe == 8'hFF, "R3 park drive flags", {t_oe, c_oe}, 16'hFFF0);
    check(t_out[3:0] == 4'hF, "R3 parked true high", t_out[3:0], 4'hF);
    prev_t7 = t_out[7];
    @(negedge clk);
    differ = (t_out[7] != prev_t7);
    check(differ, "R2 unmasked channel toggles", t_out[7], ~prev_t7);

    // R4: restart together within the window
    @(negedge clk); #1 stop_req_n = 1'b1;
    lat = 0; together = 1'b0;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (c_oe[3:0] != 0) begin lat = k; together = (c_oe[3:0] == 4'hF); break; end
    end
    check(together, "R4 channels restart in same cycle", c_oe[3:0], 4'hF);
    check(lat >= 4 && lat <= 12, "R4 restart latency", lat, 12);
    cyc(10);

    // R3 release mode
    load_cfg(8'h0F, '1, 1'b1, 1'b0);
    @(negedge clk); #1 stop_req_n = 1'b0;
    cyc(16);
    check(t_oe[3:0] == 0 && c_oe[3:0] == 0 && t_out[3:0] == 0, "R3 release mode", {t_oe[3:0], c_oe[3:0]}, 0);
    @(negedge clk); #1 stop_req_n = 1'b1;
    cyc(16);

    // R5: pin disable and register disable override stop
    load_cfg(8'h2F, 8'hBF, 1'b0, 1'b0);
    @(negedge clk); #1 begin chan_en_pin[5] = 1'b0; stop_req_n = 1'b0; end
    cyc(16);
    check(t_oe == 8'h9F, "R5 disable overrides stop (true)", t_oe, 8'h9F);
    check(c_oe == 8'h90, "R5 disable overrides stop (comp)", c_oe, 8'h90);
    @(negedge clk); #1 stop_req_n = 1'b1;
    cyc(16);

    // R9: driver comes back high
    @(negedge clk); #1 chan_en_pin[5] = 1'b1;
    lat = 0;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (t_oe[5]) begin lat = k; break; end
    end
    check(lat != 0 && t_out[5] == 1'b1, "R9 first driven value high", t_out[5], 1);
    cyc(10);

    // R6: power-down driven mode, priority over stop release mode
    load_cfg(8'h0F, 8'hBF, 1'b1, 1'b0);
    @(negedge clk); #1 begin stop_req_n = 1'b0; pwrdn_n = 1'b0; end
    cyc(16);
    check(c_oe == 8'h00 && t_oe == 8'hBF, "R6 power-down parks high", {t_oe, c_oe}, 16'hBF00);
    check(t_out == 8'hBF, "R6 parked true lines", t_out, 8'hBF);
    load_cfg(8'h0F, 8'hBF, 1'b1, 1'b1);
    cyc(16);
    check(t_oe == 8'h00 && c_oe == 8'h00, "R6 power-down release mode", {t_oe, c_oe}, 0);
    @(negedge clk); #1 begin pwrdn_n = 1'b1; stop_req_n = 1'b1; end
    cyc(16);
    check(c_oe == 8'hBF, "R6 resume after power-down", c_oe, 8'hBF);

    cyc(4);
    finish_run();
  end

endmodule